// File: doc/BRIEF.md
# Hybrid Coarse/Fine Pulse-Width Modulator

This block produces a pulse-width modulated waveform whose resolution is finer than its own clock period. The duty word is split into two fields. The upper field is compared against a free-running period counter, so the pulse lasts that many whole coarse clock cycles. The lower field is turned into a thermometer code that sets the fine time slots inside the one coarse cycle where the pulse ends.

Each coarse cycle the block emits one parallel word of 2^FINE_W bits. A downstream parallel-to-serial stage running 2^FINE_W times faster sends each word out most significant bit first, so every bit is one fine time slot. With a 125 MHz coarse clock and an 8:1 serializer, the fine step is 1 ns. The fine timing depends only on the ratio of the two clocks, so it needs no delay calibration. The duty word is captured only when a period begins, so a change to it in the middle of a period cannot shorten or split the pulse.

Top module: `hybrid_dpwm`

## Requirements
- R1: While `rst` is high at a clock edge, `wordOut` becomes all zeros after that edge. After `rst` falls, the first rising edge begins a new period at slot index 0.
- R2: In a period whose captured duty word has upper field U = duty[DUTY_W-1:FINE_W], the word for coarse index i is all ones for every i < U.
- R3: At coarse index i == U, the word is the thermometer code of the lower field K = duty[FINE_W-1:0]: exactly K ones, held in the top K bit positions (bit SLOTS-1 is the earliest slot).
- R4: For every coarse index i > U, the word is all zeros.
- R5: Serialized MSB first, each period holds exactly `duty` high fine slots. These slots form one contiguous run that starts at the first slot of the period.
- R6: The duty word is sampled only at the rising edge that begins a period. A change to `dutyIn` at any other time has no effect on the current period.
- R7: A duty word of zero gives all-zero words for the whole period.
- R8: The maximum duty word (all ones) gives 2^DUTY_W − 1 high slots. Only the last fine slot of the period is low.
- R9: A period lasts exactly 2^COARSE_W coarse cycles. The coarse index steps by one each cycle and wraps from its maximum value to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coarse clock |
| rst | input | 1 | Synchronous active-high reset |
| dutyIn | input | COARSE_W+FINE_W | Duty word in fine slots, captured at the start of each period |
| wordOut | output | 2^FINE_W | Parallel slot word for the serializer; the MSB is sent first |

## Verification
A serializer model in the bench turns every word into fine slots. For each period it counts the high slots and checks that they form one contiguous run from the start of the period. Each word is also compared with its expected all-ones, thermometer or all-zeros value. Directed duty values cover the main corner cases: zero, one, the maximum, a lower field of zero (an exact coarse multiple), and an all-ones lower field. Together these separate the coarse compare from the thermometer path and catch off-by-one errors at the boundary word. Random duty words change `dutyIn` partway through every period, which shows whether the value is captured only at the period start. Back-to-back periods check the wrap of the counter.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  // Strobes passed from the control sequencer to the datapath
  typedef struct packed {
    logic clear;  // synchronous clear of datapath state
    logic load;   // this cycle begins a new period: capture the duty word
  } dpwm_strobe_t;

endpackage

// File: rtl/dpwm_ctrl.sv
module dpwm_ctrl
  import dpwm_pkg::*;
#(
  parameter int COARSE_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  output logic [COARSE_W-1:0] periodIdx,
  output dpwm_strobe_t        strobe
);

  localparam logic [COARSE_W-1:0] IDX_MAX = '1;
  localparam logic [COARSE_W-1:0] IDX_ONE = COARSE_W'(1);

  logic [COARSE_W-1:0] idxQ;

  always_ff @(posedge clk) begin
    if (rst) idxQ <= '0;
    else     idxQ <= idxQ + IDX_ONE;
  end

  assign periodIdx    = idxQ;
  assign strobe.clear = rst;
  assign strobe.load  = !rst && (idxQ == '0);

  // R9: period index wraps from max to zero
  assert_idx_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (idxQ == IDX_MAX) |=> (idxQ == '0));

  // R9: period index advances by one each cycle below max
  assert_idx_step_R9: assert property (@(posedge clk) disable iff (rst)
    (idxQ != IDX_MAX) |=> (idxQ == $past(idxQ) + IDX_ONE));

endmodule

// File: rtl/dpwm_data.sv
module dpwm_data
  import dpwm_pkg::*;
#(
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 3,
  localparam int DUTY_W  = COARSE_W + FINE_W,
  localparam int SLOTS   = 1 << FINE_W
) (
  input  logic                clk,
  input  dpwm_strobe_t        strobe,
  input  logic [COARSE_W-1:0] periodIdx,
  input  logic [DUTY_W-1:0]   dutyIn,
  output logic [SLOTS-1:0]    wordOut
);

  localparam logic [SLOTS-1:0] WORD_ONE = SLOTS'(1);

  logic [DUTY_W-1:0]   dutyHold;
  logic [DUTY_W-1:0]   dutyEff;
  logic [COARSE_W-1:0] coarseSel;
  logic [FINE_W-1:0]   fineSel;
  logic [SLOTS-1:0]    thermo;
  logic [SLOTS-1:0]    wordNext;
  logic [SLOTS-1:0]    wordQ;

  // Duty value that governs the current coarse cycle
  assign dutyEff   = strobe.load ? dutyIn : dutyHold;
  assign coarseSel = dutyEff[DUTY_W-1:FINE_W];
  assign fineSel   = dutyEff[FINE_W-1:0];

  // Thermometer code: the earliest slots (MSB side) fill first
  for (genvar b = 0; b < SLOTS; b++) begin : g_thermo
    assign thermo[SLOTS-1-b] = (fineSel > FINE_W'(b));
  end

  always_comb begin
    if (periodIdx < coarseSel)       wordNext = '1;
    else if (periodIdx == coarseSel) wordNext = thermo;
    else                             wordNext = '0;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      dutyHold <= '0;
      wordQ    <= '0;
    end else begin
      if (strobe.load) dutyHold <= dutyIn;
      wordQ <= wordNext;
    end
  end

  assign wordOut = wordQ;

  // Checks on the datapath
  logic clearSeen;
  logic [SLOTS-1:0] wordInv;
  always_ff @(posedge clk) clearSeen <= strobe.clear;
  assign wordInv = ~wordQ;

  // R1: a clear leaves the output word at zero
  always @(posedge clk) begin
    if (clearSeen) begin
      assert_clear_word_R1: assert (wordQ == '0);
    end
  end

  // R3: every word is MSB-packed ones followed by zeros
  assert_thermo_shape_R3: assert property (@(posedge clk) disable iff (strobe.clear)
    ((wordInv & (wordInv + WORD_ONE)) == '0));

  // R4: once the pulse has ended, the period stays low
  assert_low_sticky_R4: assert property (@(posedge clk) disable iff (strobe.clear)
    (wordQ == '0 && !strobe.load) |=> (wordQ == '0));

  // R6: the captured duty value changes only when a period begins
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.load |=> $stable(dutyHold));

endmodule

// File: rtl/hybrid_dpwm.sv
module hybrid_dpwm
  import dpwm_pkg::*;
#(
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 3,
  localparam int DUTY_W  = COARSE_W + FINE_W,
  localparam int SLOTS   = 1 << FINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] dutyIn,
  output logic [SLOTS-1:0]  wordOut
);

  logic [COARSE_W-1:0] periodIdx;
  dpwm_strobe_t        strobe;

  dpwm_ctrl #(.COARSE_W(COARSE_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .periodIdx (periodIdx),
    .strobe    (strobe)
  );

  dpwm_data #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_data (
    .clk       (clk),
    .strobe    (strobe),
    .periodIdx (periodIdx),
    .dutyIn    (dutyIn),
    .wordOut   (wordOut)
  );

endmodule

// File: tb/sim_hybrid_dpwm.sv
module sim_hybrid_dpwm;

  localparam int COARSE_W = 6;
  localparam int FINE_W   = 3;
  localparam int DUTY_W   = COARSE_W + FINE_W;
  localparam int SLOTS    = 1 << FINE_W;
  localparam int PERIOD   = 1 << COARSE_W;
  localparam int DUTY_MAX = (1 << DUTY_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DUTY_W-1:0] dutyIn = '0;
  logic [SLOTS-1:0]  wordOut;

  int total = 0;
  int bad   = 0;

  hybrid_dpwm #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u0 (
    .clk     (clk),
    .rst     (rst),
    .dutyIn  (dutyIn),
    .wordOut (wordOut)
  );

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [SLOTS-1:0] expWord(int d, int i);
    int up = d >> FINE_W;
    int lo = d & (SLOTS - 1);
    logic [SLOTS-1:0] w = '0;
    if (i < up) w = '1;
    else if (i == up) begin
      for (int b = 0; b < lo; b++) w[SLOTS-1-b] = 1'b1;
    end
    return w;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Run one period with duty d; dutyIn is scrambled partway through (R6)
  task automatic runPeriod(int d);
    int highs = 0;
    int runs = 0;
    bit prev = 1'b0;
    bit firstSlot = 1'b0;
    bit lastSlot = 1'b0;
    int wordErr = 0;
    dutyIn = DUTY_W'(d);
    for (int i = 0; i < PERIOD; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (wordOut !== expWord(d, i)) begin
        wordErr++;
        if (i == 0)
          check(1'b0, "R9 first word of period", int'(wordOut), int'(expWord(d, i)));
        else if (i < (d >> FINE_W))
          check(1'b0, "R2 coarse ones word", int'(wordOut), int'(expWord(d, i)));
        else if (i == (d >> FINE_W))
          check(1'b0, "R3 thermometer word", int'(wordOut), int'(expWord(d, i)));
        else
          check(1'b0, "R4 trailing zero word", int'(wordOut), int'(expWord(d, i)));
      end
      // serializer model: MSB first, one bit per fine slot
      for (int b = SLOTS - 1; b >= 0; b--) begin
        bit s = wordOut[b];
        if (i == 0 && b == SLOTS - 1) firstSlot = s;
        if (i == PERIOD - 1 && b == 0) lastSlot = s;
        if (s) highs++;
        if (s && !prev) runs++;
        prev = s;
      end
      if (i == PERIOD / 3) dutyIn = DUTY_W'($urandom);
    end
    check(wordErr == 0, "R2 R3 R4 words in period", wordErr, 0);
    check(highs == d, "R5 R6 high slot count", highs, d);
    check(runs == (d > 0 ? 1 : 0), "R5 contiguous pulse", runs, d > 0 ? 1 : 0);
    if (d > 0) check(firstSlot == 1'b1, "R5 pulse starts at first slot", int'(firstSlot), 1);
    if (d == 0) check(highs == 0, "R7 zero duty stays low", highs, 0);
    if (d == DUTY_MAX) begin
      check(lastSlot == 1'b0, "R8 last slot low", int'(lastSlot), 0);
      check(highs == DUTY_MAX, "R8 max high slots", highs, DUTY_MAX);
    end
  endtask

  initial begin
    void'($urandom(32'd20240513));
    dutyIn = DUTY_W'(DUTY_MAX);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(wordOut == '0, "R1 word zero in reset", int'(wordOut), 0);
    // reset mid-stream: run part of a period, then reset again
    rst = 1'b0;
    dutyIn = DUTY_W'(DUTY_MAX);
    repeat (10) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(wordOut == '0, "R1 word cleared by reset", int'(wordOut), 0);
    rst = 1'b0;
    // directed corners, back to back (R9 wrap between them)
    runPeriod(0);
    runPeriod(DUTY_MAX);
    runPeriod(1);
    runPeriod(SLOTS);
    runPeriod(SLOTS - 1);
    runPeriod(DUTY_MAX - (SLOTS - 1));
    runPeriod(1 << (DUTY_W - 1));
    runPeriod(DUTY_MAX);
    runPeriod(0);
    for (int n = 0; n < 24; n++) runPeriod(int'($urandom % (DUTY_MAX + 1)));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule